// File: doc/BRIEF.md
# Programmable Up/Down Timer Counter

This block counts timer ticks in either direction, as an 8-bit or as a 16-bit counter. A tick comes from one of four divided strobes of an internal clock divider that lies outside the block, from every clock cycle, or from one chosen edge of an asynchronous external pin. The pin passes through a synchroniser and an edge detector. A three-bit select field picks the tick source. Setting that field to zero stops the counter, and the counter then holds its value.

The upper end of the count sequence is either the full-scale value or a programmed compare word. In 16-bit mode the two 8-bit compare registers form that word. The block shows three conditions at its ports: zero, full scale and upper end. It also keeps a sticky overflow flag. Software reaches the count, the compare registers, the control field and the flag through a byte-wide register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `tcu_timer`

## Requirements
- R1: After reset the count, both compare registers, the control register and the overflow flag read as zero, and the counter is stopped.
- R2: Control bits [2:0] hold the tick select. With select 000 the count does not change, whatever the divider strobes and the external pin do.
- R3: Select 001 ticks on every clock. Selects 010, 011, 100 and 101 tick only on divider strobes tap[0], tap[1], tap[2] and tap[3] (divide-by 8, 64, 256 and 1024). A strobe on a tap that is not selected is ignored.
- R4: Select 110 counts once for each falling edge of the external pin and select 111 counts once for each rising edge. The edge that is not selected is ignored. The count changes on the third clock edge after the pin changes.
- R5: Control bit 4 = 0 counts up. When the count equals TOP, the next tick wraps it to zero. Control bit 5 selects TOP: 0 = full scale, 1 = compare word.
- R6: Control bit 4 = 1 counts down by one per tick. A tick at zero loads TOP.
- R7: Control bit 3 = 0 gives 8-bit mode: full scale is 0xFF, the compare word is register A, and ticks never change the high count byte. Control bit 3 = 1 gives 16-bit mode: full scale is 0xFFFF and the compare word is {B, A}, with A as the low byte.
- R8: Output at_bottom is high when the active count is zero, at_max when it equals full scale, and at_top when it equals TOP.
- R9: A tick that produces the full-scale value sets the overflow flag (register 5, bit 0). The flag stays set until a one is written to that bit. Writing zero has no effect.
- R10: A write to either count byte in the same cycle as a tick takes priority, and that tick is lost.
- R11: Register addresses: 0 count low, 1 count high, 2 compare A, 3 compare B, 4 control (bits [5:0], bits 7:6 read as zero), 5 flag. Written values read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr, combinational |
| div_tap | input | 4 | Single-cycle strobes from the external divider (/8, /64, /256, /1024) |
| ext_pin | input | 1 | Asynchronous external count pin |
| at_bottom | output | 1 | Active count is zero |
| at_max | output | 1 | Active count is full scale |
| at_top | output | 1 | Active count equals TOP |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default data width of 8 and a two-stage synchroniser. These values give an 8-bit mode whose full scale of 0xFF is reached in a few ticks, and a 16-bit mode in which preloading the count next to 0xFFFF or next to {B, A} shows the carry between bytes and the wrap. The divider taps are driven as strobes from the bench, so each select code is checked with an exact tick count. The fixed synchroniser depth makes the three-edge latency from the pin to the count a known value.

// File: rtl/tcu_pkg.sv
// Package tcu_pkg
// Shared register addresses, control bit positions and tick-select codes
// for the timer counter. Assumes an 8-bit register data path.
package tcu_pkg;
    localparam int ADDR_W    = 3;
    localparam int NUM_TAPS  = 4;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP_A  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP_B  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAG   = 3'd5;

    localparam int CTRL_W    = 6;
    localparam int B_WIDE    = 3;
    localparam int B_DOWN    = 4;
    localparam int B_USECMP  = 5;

    typedef enum logic [2:0] {
        SEL_OFF  = 3'b000,
        SEL_D1   = 3'b001,
        SEL_D8   = 3'b010,
        SEL_D64  = 3'b011,
        SEL_D256 = 3'b100,
        SEL_D1K  = 3'b101,
        SEL_FALL = 3'b110,
        SEL_RISE = 3'b111
    } tick_sel_e;
endpackage

// File: rtl/tcu_ext_edge.sv
// Module tcu_ext_edge
// Brings an asynchronous pin into the clock domain through SYNC_STAGES
// flops, then marks rising and falling edges as single-cycle pulses.
// Assumes the pin is low while reset is applied.
module tcu_ext_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES:0] sh_q;

    // Shift the pin through the synchroniser and keep one extra history bit.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC_STAGES-1:0], pin};
    end

    // Edge detection compares the last synchronised bit with the one before.
    always_comb begin
        rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
        fall = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];
    end

    a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    a_r4_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/tcu_tick_sel.sv
// Module tcu_tick_sel
// Turns the 3-bit select code into one tick strobe, taken from the clock,
// from a divider tap, or from an edge of the synchronised external pin.
// Assumes the divider taps are single-cycle strobes.
module tcu_tick_sel
    import tcu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          sel,
    input  logic [NUM_TAPS-1:0] div_tap,
    input  logic                ext_pin,
    output logic                tick
);
    logic ext_rise, ext_fall;

    tcu_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_pin),
        .rise (ext_rise),
        .fall (ext_fall)
    );

    // Select the tick source named by the select code.
    always_comb begin
        unique case (tick_sel_e'(sel))
            SEL_OFF:  tick = 1'b0;
            SEL_D1:   tick = 1'b1;
            SEL_D8:   tick = div_tap[0];
            SEL_D64:  tick = div_tap[1];
            SEL_D256: tick = div_tap[2];
            SEL_D1K:  tick = div_tap[3];
            SEL_FALL: tick = ext_fall;
            SEL_RISE: tick = ext_rise;
            default:  tick = 1'b0;
        endcase
    end

    a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'b000) |-> !tick);
endmodule

// File: rtl/tcu_count.sv
// Module tcu_count
// Counter unit. On each tick it steps the count by one, up or down, and
// wraps at TOP or at zero. A byte write wins over a tick in the same cycle.
// In narrow mode only the low byte takes part in counting.
module tcu_count #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            count_down,
    input  logic            wide,
    input  logic            use_cmp,
    input  logic [2*DW-1:0] cmp_word,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [DW-1:0]   wr_data,
    output logic [2*DW-1:0] cnt_q,
    output logic            at_bottom,
    output logic            at_max,
    output logic            at_top,
    output logic            ovf_evt
);
    localparam int CW = 2 * DW;

    logic [CW-1:0] cur, max_v, top_v, step;
    logic          wr_any;

    // Work out the active count, full scale, TOP and the stepped value.
    always_comb begin
        wr_any = wr_lo | wr_hi;
        max_v  = wide ? {CW{1'b1}} : {{DW{1'b0}}, {DW{1'b1}}};
        cur    = wide ? cnt_q : {{DW{1'b0}}, cnt_q[DW-1:0]};
        if (use_cmp) top_v = wide ? cmp_word : {{DW{1'b0}}, cmp_word[DW-1:0]};
        else         top_v = max_v;
        if (!count_down) step = (cur == top_v) ? '0 : cur + 1'b1;
        else             step = (cur == '0) ? top_v : cur - 1'b1;
        at_bottom = (cur == '0);
        at_max    = (cur == max_v);
        at_top    = (cur == top_v);
        ovf_evt   = tick & ~wr_any & (step == max_v);
    end

    // Hold the count register, applying writes before ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_any) begin
            if (wr_lo) cnt_q[DW-1:0]  <= wr_data;
            if (wr_hi) cnt_q[CW-1:DW] <= wr_data;
        end else if (tick) begin
            if (wide) cnt_q <= step;
            else      cnt_q[DW-1:0] <= step[DW-1:0];
        end
    end

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_any) |=> $stable(cnt_q));
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cnt_q[DW-1:0] == $past(wr_data)));
    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_any && !count_down && at_top) |=> (cnt_q[DW-1:0] == '0));
    a_r6_reload_top: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_any && count_down && at_bottom)
            |=> (cnt_q[DW-1:0] == $past(top_v[DW-1:0])));
    a_r7_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wide && !wr_any) |=> $stable(cnt_q[CW-1:DW]));
endmodule

// File: rtl/tcu_timer.sv
// Module tcu_timer
// Top of the timer counter: register file, tick selection and counter
// unit. Writes act on the clock edge and reads are combinational. The
// overflow flag is sticky and is cleared by writing one.
module tcu_timer
    import tcu_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    input  logic [NUM_TAPS-1:0] div_tap,
    input  logic              ext_pin,
    output logic              at_bottom,
    output logic              at_max,
    output logic              at_top,
    output logic              ovf_flag
);
    logic [DW-1:0]     cmp_a_q, cmp_b_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [2*DW-1:0]   cnt_w;
    logic              tick, ovf_evt, ovf_q, ovf_clr;

    // Compare and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_a_q <= '0;
            cmp_b_q <= '0;
            ctrl_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_CMP_A) cmp_a_q <= wr_data;
            if (addr == A_CMP_B) cmp_b_q <= wr_data;
            if (addr == A_CTRL)  ctrl_q  <= wr_data[CTRL_W-1:0];
        end
    end

    assign ovf_clr = wr_en && (addr == A_FLAG) && wr_data[0];

    // Sticky overflow flag; a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (ovf_evt) ovf_q <= 1'b1;
        else if (ovf_clr) ovf_q <= 1'b0;
    end

    assign ovf_flag = ovf_q;

    tcu_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (ctrl_q[2:0]),
        .div_tap(div_tap),
        .ext_pin(ext_pin),
        .tick   (tick)
    );

    tcu_count #(.DW(DW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .count_down(ctrl_q[B_DOWN]),
        .wide      (ctrl_q[B_WIDE]),
        .use_cmp   (ctrl_q[B_USECMP]),
        .cmp_word  ({cmp_b_q, cmp_a_q}),
        .wr_lo     (wr_en && (addr == A_CNT_LO)),
        .wr_hi     (wr_en && (addr == A_CNT_HI)),
        .wr_data   (wr_data),
        .cnt_q     (cnt_w),
        .at_bottom (at_bottom),
        .at_max    (at_max),
        .at_top    (at_top),
        .ovf_evt   (ovf_evt)
    );

    // Read multiplexer over the register map.
    always_comb begin
        rd_data = '0;
        case (addr)
            A_CNT_LO: rd_data = cnt_w[DW-1:0];
            A_CNT_HI: rd_data = cnt_w[2*DW-1:DW];
            A_CMP_A:  rd_data = cmp_a_q;
            A_CMP_B:  rd_data = cmp_b_q;
            A_CTRL:   rd_data = {{(DW-CTRL_W){1'b0}}, ctrl_q};
            A_FLAG:   rd_data = {{(DW-1){1'b0}}, ovf_q};
            default:  rd_data = '0;
        endcase
    end

    a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !ovf_evt) |=> !ovf_flag);
endmodule

// File: tb/tcu_timer_bench.sv
module tcu_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [3:0] div_tap = '0;
    logic       ext_pin = 1'b0;
    logic       at_bottom, at_max, at_top, ovf_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcu_timer u_tcu_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .div_tap(div_tap),
        .ext_pin(ext_pin), .at_bottom(at_bottom), .at_max(at_max),
        .at_top(at_top), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Write one register; consumes one rising edge, returns at a falling edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        addr = a; #1; v = rd_data;
    endtask

    task automatic pulse_tap(input int idx);
        div_tap[idx] = 1'b1;
        @(negedge clk);
        div_tap = '0;
    endtask

    task automatic pin_to(input logic v);
        ext_pin = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        int v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R1 reset reg", v, 0);
        end
        check("R1 bottom", at_bottom, 1);
        check("R1 ovf", ovf_flag, 0);
        check("R8 top at reset", at_top, 0);
    endtask

    task automatic t_regs;
        int v;
        wr(3'd2, 8'h5A); rd(3'd2, v); check("R11 cmpA", v, 'h5A);
        wr(3'd3, 8'hC3); rd(3'd3, v); check("R11 cmpB", v, 'hC3);
        wr(3'd4, 8'hF8); rd(3'd4, v); check("R11 ctrl", v, 'h38);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_stop;
        int v;
        wr(3'd0, 8'h10);
        for (int i = 0; i < 4; i++) pulse_tap(i);
        pin_to(1'b1); pin_to(1'b0);
        rd(3'd0, v); check("R2 stopped", v, 'h10);
    endtask

    task automatic t_internal;
        int v;
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h02);
        pulse_tap(0); pulse_tap(1); pulse_tap(0); pulse_tap(2); pulse_tap(0);
        rd(3'd0, v); check("R3 tap0", v, 3);
        wr(3'd4, 8'h05);
        pulse_tap(3); pulse_tap(0); pulse_tap(3);
        rd(3'd0, v); check("R3 tap3", v, 5);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h01);
        repeat (5) @(negedge clk);
        wr(3'd4, 8'h00);
        rd(3'd0, v); check("R3 every clock", v, 6);
    endtask

    task automatic t_external;
        int v;
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h07);
        ext_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(3'd0, v); check("R4 latency not yet", v, 0);
        @(negedge clk);
        rd(3'd0, v); check("R4 latency third edge", v, 1);
        pin_to(1'b0);
        rd(3'd0, v); check("R4 falling ignored", v, 1);
        pin_to(1'b1); pin_to(1'b0);
        rd(3'd0, v); check("R4 rising", v, 2);
        wr(3'd4, 8'h06);
        pin_to(1'b1);
        rd(3'd0, v); check("R4 rising ignored", v, 2);
        pin_to(1'b0);
        rd(3'd0, v); check("R4 falling", v, 3);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_up_wrap;
        int v;
        wr(3'd2, 8'h05); wr(3'd0, 8'h03);
        wr(3'd4, 8'h22);
        pulse_tap(0); pulse_tap(0);
        rd(3'd0, v); check("R5 reach top", v, 5);
        check("R8 at_top", at_top, 1);
        pulse_tap(0);
        rd(3'd0, v); check("R5 wrap", v, 0);
        check("R8 at_bottom", at_bottom, 1);
        check("R9 no ovf below max", ovf_flag, 0);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_down;
        int v;
        wr(3'd2, 8'h05); wr(3'd0, 8'h01);
        wr(3'd4, 8'h32);
        pulse_tap(0);
        rd(3'd0, v); check("R6 reach zero", v, 0);
        pulse_tap(0);
        rd(3'd0, v); check("R6 reload top", v, 5);
        pulse_tap(0);
        rd(3'd0, v); check("R6 decrement", v, 4);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_ovf;
        int v;
        wr(3'd0, 8'hFE);
        wr(3'd4, 8'h02);
        pulse_tap(0);
        check("R8 at_max", at_max, 1);
        check("R9 set", ovf_flag, 1);
        pulse_tap(0);
        rd(3'd0, v); check("R5 wrap at max", v, 0);
        check("R9 sticky", ovf_flag, 1);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'h00);
        check("R9 write zero ignored", ovf_flag, 1);
        wr(3'd5, 8'h01);
        check("R9 cleared", ovf_flag, 0);
    endtask

    task automatic t_wide;
        int v, w;
        wr(3'd2, 8'h34); wr(3'd3, 8'h12);
        wr(3'd0, 8'h33); wr(3'd1, 8'h12);
        wr(3'd4, 8'h2A);
        pulse_tap(0);
        rd(3'd0, v); rd(3'd1, w);
        check("R7 wide reach top", (w << 8) | v, 'h1234);
        check("R8 wide at_top", at_top, 1);
        pulse_tap(0);
        rd(3'd0, v); rd(3'd1, w);
        check("R7 wide wrap", (w << 8) | v, 0);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'hFF); wr(3'd1, 8'h00);
        wr(3'd4, 8'h0A);
        pulse_tap(0);
        rd(3'd0, v); rd(3'd1, w);
        check("R7 carry", (w << 8) | v, 'h0100);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'hFE); wr(3'd1, 8'hFF);
        wr(3'd4, 8'h0A);
        pulse_tap(0);
        check("R7 wide max", at_max, 1);
        check("R9 wide ovf", ovf_flag, 1);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'h01);
        wr(3'd0, 8'hFF); wr(3'd1, 8'h77);
        wr(3'd4, 8'h02);
        pulse_tap(0);
        rd(3'd0, v); rd(3'd1, w);
        check("R7 narrow low wraps", v, 0);
        check("R7 narrow high kept", w, 'h77);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'h01);
    endtask

    task automatic t_wr_prio;
        int v;
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h01);
        wr(3'd0, 8'h40);
        rd(3'd0, v); check("R10 write wins", v, 'h40);
        wr(3'd4, 8'h00);
        rd(3'd0, v); check("R10 counting resumes", v, 'h41);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_stop();
        t_internal();
        t_external();
        t_up_wrap();
        t_down();
        t_ovf();
        t_wide();
        t_wr_prio();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=0x0 expected=0x1");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule